// File: doc/BRIEF.md
# Register-Driven Serial DAC Frame Writer

This block sits behind a simple register port and turns each 32-bit word written to its data register into one serial frame for an external digital-to-analog converter. A frame opens with the active-low frame-sync line falling. The word then leaves most significant bit first on the data line, with one bit per serial clock period, and the converter takes each bit on a falling serial clock edge. After the 32nd falling edge the sync line returns high. It stays high for an enforced minimum gap before another frame may begin.

Software writes a divider value to a second register address to slow the serial clock for slow converters. The divider is taken at the start of each frame. Reading the data address returns a nonzero status while a frame or its trailing gap is in progress, and zero once the block is idle. A write to the data address that arrives while the block is busy is dropped. The word is passed through untouched, so command, channel and data fields are whatever software packs into it. For example, a command in bits 27..24, a channel in bits 23..20 with 1111 meaning all channels, and data from bit 19 downward.

Top module: `sdw_writer`

## Requirements
- R1: After reset, dac_sync_n and dac_sclk are high and dac_din is low. A status read (reg_sel=0) returns 0 and a divider read (reg_sel=1) returns 0.
- R2: A write with reg_sel=0 while idle drives dac_sync_n low in the cycle after the write cycle. The frame opens with dac_sclk high.
- R3: The 32 bits of the written word appear on dac_din most significant bit first, one per falling dac_sclk edge. Any bit pattern is reproduced exactly, including the bits 27..24 and 23..20 fields.
- R4: While dac_sync_n stays low, dac_din changes only in the same cycle as a rising dac_sclk edge. It is therefore stable across every falling edge.
- R5: With divider value D (written at reg_sel=1), the first falling dac_sclk edge comes D+1 cycles after dac_sync_n falls. Falling edges then follow every 2*(D+1) cycles. D=0 gives the fastest rate.
- R6: Each frame holds exactly 32 falling dac_sclk edges. Half a serial period after the 32nd falling edge, dac_sclk and dac_sync_n return high together. While dac_sync_n is high, dac_sclk is high.
- R7: A read with rd_en updates rdata in the next cycle. At reg_sel=0, rdata is nonzero from the accepted write until the end of the trailing gap, and 0 otherwise.
- R8: A write at reg_sel=0 while busy is ignored: the current frame carries the first word, no extra frame follows, and the status stays nonzero.
- R9: Between frames dac_sync_n stays high for at least GAP_CYCLES cycles. When a data write is held asserted continuously, the high time is exactly GAP_CYCLES+1 cycles.
- R10: A read at reg_sel=1 returns the divider value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 selects the data/status register, 1 the divider |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| dac_sync_n | output | 1 | Active-low frame sync |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_din | output | 1 | Serial data, MSB first |

## Verification
Frames are sent with a packed command/channel/data word, alternating nibble and byte patterns, a lone low-order one and an all-ones-but-bit-zero word. Together these catch bit-order reversal, dropped or duplicated end bits and shift misalignment. Divider values 0, 1, 2 and 5 separate a correct half-period count from an off-by-one in the first edge or in the edge spacing. A write landing mid-frame, and a write held high across a whole frame and its gap, tell apart a dropped busy write from a restart or a queued frame, and pin the exact gap length.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  localparam logic SEL_DATA = 1'b0;
  localparam logic SEL_DIV  = 1'b1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } sdw_state_t;
endpackage

// File: rtl/sdw_regs.sv
module sdw_regs
  import sdw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              reg_sel,
  input  logic [DIV_W-1:0]  wdiv,
  input  logic              busy,
  output logic [DIV_W-1:0]  div_q,
  output logic [DATA_W-1:0] rdata,
  output logic              start
);
  assign start = wr_en && (reg_sel == SEL_DATA) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      rdata <= '0;
    end else begin
      if (wr_en && (reg_sel == SEL_DIV))
        div_q <= wdiv;
      if (rd_en)
        rdata <= (reg_sel == SEL_DIV) ? DATA_W'(div_q) : DATA_W'(busy);
    end
  end
endmodule

// File: rtl/sdw_halftick.sv
module sdw_halftick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] hcnt;

  assign tick = run && (hcnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run || tick)
      hcnt <= '0;
    else
      hcnt <= hcnt + 1'b1;
  end
endmodule

// File: rtl/sdw_shifter.sv
module sdw_shifter
  import sdw_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DIV_W      = 8,
  parameter int GAP_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] word,
  input  logic [DIV_W-1:0]  div,
  input  logic              tick,
  output logic [DIV_W-1:0]  div_lat,
  output logic              run,
  output logic              busy,
  output logic              sync_n,
  output logic              sclk,
  output logic              din
);
  localparam int FCNT_W = $clog2(DATA_W + 1);
  localparam int GCNT_W = $clog2(GAP_CYCLES) + 1;

  sdw_state_t        state;
  logic [DATA_W-1:0] shreg;
  logic [FCNT_W-1:0] fcnt;
  logic [GCNT_W-1:0] gcnt;

  assign run  = (state == ST_XFER);
  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      fcnt    <= '0;
      gcnt    <= '0;
      div_lat <= '0;
      sync_n  <= 1'b1;
      sclk    <= 1'b1;
      din     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_XFER;
            shreg   <= word;
            din     <= word[DATA_W-1];
            div_lat <= div;
            fcnt    <= '0;
            sync_n  <= 1'b0;
            sclk    <= 1'b1;
          end
        end
        ST_XFER: begin
          if (tick) begin
            if (sclk) begin
              sclk <= 1'b0;
              fcnt <= fcnt + 1'b1;
            end else if (fcnt == FCNT_W'(DATA_W)) begin
              sclk   <= 1'b1;
              sync_n <= 1'b1;
              din    <= 1'b0;
              gcnt   <= '0;
              state  <= ST_GAP;
            end else begin
              sclk  <= 1'b1;
              shreg <= {shreg[DATA_W-2:0], 1'b0};
              din   <= shreg[DATA_W-2];
            end
          end
        end
        ST_GAP: begin
          if (gcnt == GCNT_W'(GAP_CYCLES - 1))
            state <= ST_IDLE;
          else
            gcnt <= gcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdw_writer.sv
module sdw_writer
  import sdw_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DIV_W      = 8,
  parameter int GAP_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              dac_sync_n,
  output logic              dac_sclk,
  output logic              dac_din
);
  logic             busy;
  logic             start;
  logic             run;
  logic             tick;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_lat;

  sdw_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wdiv(wdata[DIV_W-1:0]), .busy(busy), .div_q(div_q), .rdata(rdata),
    .start(start)
  );

  sdw_halftick #(.DIV_W(DIV_W)) i_tick (
    .clk(clk), .rst(rst), .run(run), .div(div_lat), .tick(tick)
  );

  sdw_shifter #(.DATA_W(DATA_W), .DIV_W(DIV_W), .GAP_CYCLES(GAP_CYCLES)) i_shift (
    .clk(clk), .rst(rst), .start(start), .word(wdata), .div(div_q),
    .tick(tick), .div_lat(div_lat), .run(run), .busy(busy),
    .sync_n(dac_sync_n), .sclk(dac_sclk), .din(dac_din)
  );
endmodule

// File: rtl/sdw_checker.sv
module sdw_checker #(
  parameter int DATA_W     = 32,
  parameter int GAP_CYCLES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              reg_sel,
  input logic [DATA_W-1:0] rdata,
  input logic              busy,
  input logic              sync_n,
  input logic              sclk,
  input logic              din
);
  localparam int HI_W = $clog2(GAP_CYCLES + 1) + 1;
  logic [HI_W-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)
      hi_cnt <= HI_W'(GAP_CYCLES);
    else if (!sync_n)
      hi_cnt <= '0;
    else if (hi_cnt < HI_W'(GAP_CYCLES))
      hi_cnt <= hi_cnt + 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (sync_n && sclk && !din && !busy));

  assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_n) |-> $past(wr_en && (reg_sel == 1'b0) && !busy));

  assert_din_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
    (!sync_n && $past(!sync_n) && !$stable(din)) |-> $rose(sclk));

  assert_clock_idles_high_R6: assert property (@(posedge clk) disable iff (rst)
    sync_n |-> sclk);

  assert_status_read_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (reg_sel == 1'b0)) |=> ((rdata != '0) == $past(busy)));

  assert_sync_gap_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_n) |-> (hi_cnt >= HI_W'(GAP_CYCLES)));
endmodule

bind sdw_writer sdw_checker #(.DATA_W(DATA_W), .GAP_CYCLES(GAP_CYCLES)) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
  .rdata(rdata), .busy(busy), .sync_n(dac_sync_n), .sclk(dac_sclk),
  .din(dac_din)
);

// File: tb/test_sdw_writer.sv
`timescale 1ns/1ps
module test_sdw_writer;
  localparam int GAP = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        dac_sync_n, dac_sclk, dac_din;

  int n_checks = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  sdw_writer #(.DATA_W(32), .DIV_W(8), .GAP_CYCLES(GAP)) i_sdw_writer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wdata(wdata), .rdata(rdata), .dac_sync_n(dac_sync_n),
    .dac_sclk(dac_sclk), .dac_din(dac_din)
  );

  // line monitor, samples at falling system clock edge
  int cyc = 0, pend_wr = 0, start_wr = 0, fall_cyc = 0, tprev = 0;
  int sync_falls = 0, frames = 0, nfall = 0, last_nfall = 0;
  int first_delay = 0, sp_min = 0, sp_max = 0, stab_err = 0;
  int hi_cnt = 1000, last_gap = 0;
  logic [31:0] cap = '0, last_word = '0;
  logic prev_sync = 1'b1, prev_sclk = 1'b1, prev_din = 1'b0, end_sclk = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst) begin
      if (wr_en && reg_sel == 1'b0) pend_wr = cyc;
      if (prev_sync && !dac_sync_n) begin
        sync_falls++;
        fall_cyc = cyc; start_wr = pend_wr; last_gap = hi_cnt;
        nfall = 0; cap = '0; tprev = cyc; sp_min = 1000000; sp_max = 0;
      end else if (!dac_sync_n) begin
        if (dac_din != prev_din && !(!prev_sclk && dac_sclk)) stab_err++;
        if (prev_sclk && !dac_sclk) begin
          cap = {cap[30:0], dac_din};
          if (nfall == 0) first_delay = cyc - tprev;
          else begin
            if (cyc - tprev < sp_min) sp_min = cyc - tprev;
            if (cyc - tprev > sp_max) sp_max = cyc - tprev;
          end
          tprev = cyc;
          nfall++;
        end
      end
      if (!prev_sync && dac_sync_n) begin
        frames++; last_word = cap; last_nfall = nfall; end_sclk = dac_sclk;
      end
      hi_cnt = dac_sync_n ? hi_cnt + 1 : 0;
    end
    prev_sync = dac_sync_n; prev_sclk = dac_sclk; prev_din = dac_din;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [31:0] val);
    @(posedge clk); #1;
    wr_en = 1'b1; reg_sel = sel; wdata = val;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic sel, output logic [31:0] val);
    @(posedge clk); #1;
    rd_en = 1'b1; reg_sel = sel;
    @(posedge clk); #1;
    rd_en = 1'b0;
    val = rdata;
  endtask

  task automatic wait_frames(input int n);
    while (frames < n) @(negedge clk);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    reg_read(1'b0, s);
    for (int k = 0; k < 200 && s != 0; k++) reg_read(1'b0, s);
    check(s == 0, "R7 status zero when idle", s, 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check(dac_sync_n === 1'b1, "R1 sync idle high", dac_sync_n, 1);
    check(dac_sclk === 1'b1, "R1 sclk idle high", dac_sclk, 1);
    check(dac_din === 1'b0, "R1 din idle low", dac_din, 0);
    reg_read(1'b0, v);
    check(v == 0, "R1 status after reset", v, 0);
    reg_read(1'b1, v);
    check(v == 0, "R1 divider after reset", v, 0);
  endtask

  task automatic t_frame(input logic [31:0] word, input int d);
    logic [31:0] v;
    int f0;
    f0 = frames;
    reg_write(1'b1, d);
    reg_read(1'b1, v);
    check(v == d, "R10 divider readback", v, d);
    reg_write(1'b0, word);
    wait_frames(f0 + 1);
    reg_read(1'b0, v);
    check(v != 0, "R7 status busy during gap", v, 1);
    check(fall_cyc - start_wr == 1, "R2 sync falls one cycle after write",
          fall_cyc - start_wr, 1);
    check(last_word == word, "R3 shifted word", last_word, word);
    check(last_nfall == 32, "R6 falling edge count", last_nfall, 32);
    check(end_sclk == 1'b1, "R6 sclk high at sync rise", end_sclk, 1);
    check(first_delay == d + 1, "R5 first falling edge delay", first_delay, d + 1);
    check(sp_min == 2 * (d + 1) && sp_max == 2 * (d + 1), "R5 edge spacing",
          sp_max, 2 * (d + 1));
    check(stab_err == 0, "R4 din changes only on rising sclk", stab_err, 0);
    wait_idle();
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    int f0;
    f0 = frames;
    reg_write(1'b1, 3);
    reg_write(1'b0, 32'h3C5A_96E1);
    repeat (20) @(posedge clk);
    reg_read(1'b0, v);
    check(v != 0, "R7 status busy mid-frame", v, 1);
    reg_write(1'b0, 32'h0F0F_1234);
    reg_read(1'b0, v);
    check(v != 0, "R8 busy stays after ignored write", v, 1);
    wait_frames(f0 + 1);
    check(last_word == 32'h3C5A_96E1, "R8 frame keeps first word", last_word,
          32'h3C5A_96E1);
    wait_idle();
    repeat (300) @(posedge clk);
    check(frames == f0 + 1, "R8 no extra frame", frames - f0, 1);
  endtask

  task automatic t_gap();
    int s0, f0;
    s0 = sync_falls; f0 = frames;
    reg_write(1'b1, 0);
    reg_write(1'b0, 32'hC0DE_0001);
    @(posedge clk); #1;
    wr_en = 1'b1; reg_sel = 1'b0; wdata = 32'h8421_7EB5;
    while (sync_falls < s0 + 2) @(negedge clk);
    @(posedge clk); #1;
    wr_en = 1'b0;
    check(last_gap == GAP + 1, "R9 sync gap with held write", last_gap, GAP + 1);
    wait_frames(f0 + 2);
    check(last_word == 32'h8421_7EB5, "R3 second frame word", last_word,
          32'h8421_7EB5);
    check(stab_err == 0, "R4 din stable in back-to-back frames", stab_err, 0);
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (2) @(posedge clk);
    t_reset();
    t_frame(32'h03FA_5C30, 0);
    t_frame(32'hA5A5_0F0F, 2);
    t_frame(32'h0000_0001, 5);
    t_frame(32'hFFFF_FFFE, 1);
    t_ignore();
    t_gap();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule